// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block sits between an 8-bit microcontroller and its external peripherals. On that controller's bus the low address byte and the data byte share one 8-bit port, and a separate port carries the high address byte. Each bus access has two halves. In the first half the shared port shows address bits 7:0, and the address latch enable strobe is high. In the second half the same port carries data, and an active-low read or write strobe marks the transfer.

The block captures the low address byte while the enable strobe is high and holds it once the strobe has fallen. It joins that byte with the high-address port to form a stable 16-bit address, which it flags valid only while a strobe is active. It gives peripherals qualified read and write strobes and the write data. For reads it drives the peripheral's data back toward the CPU. It also keeps a sticky error flag, which is set when both strobes are seen low together.

The shared port is modelled as a separate input bus, an output bus and a drive-enable. The latch is built from one register plus a bypass. While the enable strobe is high the low-address output follows the port without delay. After the strobe falls, the output holds the port value sampled at the last clock edge at which the strobe was still high.

Top module: `bus_demux`

## Requirements
- R1: While `ale` is high, `addr_lo` equals `ad_in` in the same cycle, with no clock delay.
- R2: While `ale` is low, `addr_lo` holds the `ad_in` value sampled at the last rising clock edge at which `ale` was high. Changes on `ad_in` during the data half do not alter it.
- R3: `addr` equals {`addr_hi`, `addr_lo`}, with the high byte in bits 15:8. `addr_valid` is 1 exactly when `rd_n` or `wr_n` is low.
- R4: `wr_stb` is 1 exactly when `wr_n` is low and `rd_n` is high. `wr_data` always equals `ad_in`.
- R5: `rd_stb` and `ad_oe` are 1 exactly when `rd_n` is low and `wr_n` is high. `ad_out` always equals `rd_data`.
- R6: `rd_stb` and `wr_stb` are never 1 together. A rising clock edge that samples `rd_n` and `wr_n` both low sets `err` from the next cycle on. `err` stays set until reset.
- R7: A synchronous reset (`rst` high at a rising edge) clears the held low address to 00h and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_in | input | 8 | Shared port as driven by the CPU (address byte, then write data) |
| addr_hi | input | 8 | High address byte port |
| ale | input | 1 | Address latch enable, high during the address half |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_data | input | 8 | Data returned by the selected peripheral |
| ad_out | output | 8 | Data driven toward the CPU on the shared port |
| ad_oe | output | 1 | Drive-enable for `ad_out` |
| addr | output | 16 | Rebuilt 16-bit address |
| addr_lo | output | 8 | Latched low address byte |
| addr_valid | output | 1 | Address is valid (a strobe is active) |
| wr_data | output | 8 | Write data to peripherals |
| wr_stb | output | 1 | Qualified write strobe |
| rd_stb | output | 1 | Qualified read strobe |
| err | output | 1 | Sticky flag for both strobes seen low together |

## Verification
The assertions assume a reset is applied before any access. They also assume that the strobes change only between clock edges, so every edge samples a settled level. The stimulus follows the controller's real cycle: it raises `ale` with the address byte, drops it a cycle later before any strobe goes low, and then pulses exactly one strobe. The single deliberate overlap of both strobes is a directed case. It is followed by a reset, so the sticky flag does not hide the later checks.

// File: rtl/bus_demux.sv
module bus_demux (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  ad_in,
  input  logic [7:0]  addr_hi,
  input  logic        ale,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [7:0]  rd_data,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [15:0] addr,
  output logic [7:0]  addr_lo,
  output logic        addr_valid,
  output logic [7:0]  wr_data,
  output logic        wr_stb,
  output logic        rd_stb,
  output logic        err
);

  logic [7:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst)
      lo_q <= 8'h00;
    else if (ale)
      lo_q <= ad_in;
  end

  always_ff @(posedge clk) begin
    if (rst)
      err <= 1'b0;
    else if (!rd_n && !wr_n)
      err <= 1'b1;
  end

  assign addr_lo    = ale ? ad_in : lo_q;
  assign addr       = {addr_hi, addr_lo};
  assign addr_valid = !rd_n || !wr_n;
  assign wr_stb     = !wr_n && rd_n;
  assign rd_stb     = !rd_n && wr_n;
  assign wr_data    = ad_in;
  assign ad_out     = rd_data;
  assign ad_oe      = rd_stb;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ale && $past(!ale) && $past(!rst)) |-> addr_lo == $past(addr_lo));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(ale) && !ale && $past(!rst)) |-> addr_lo == $past(ad_in));

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |-> (!wr_stb && !rd_stb && !ad_oe));

  p_oe_r5: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!rd_n && rd_stb));

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !wr_n) |=> err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_reset_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !ale) |-> (addr_lo == 8'h00 && !err));

endmodule

// File: tb/test_bus_demux.sv
module test_bus_demux;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  ad_in = 0, addr_hi = 0, rd_data = 0;
  logic        ale = 0, rd_n = 1, wr_n = 1;
  logic [7:0]  ad_out, addr_lo, wr_data;
  logic        ad_oe, addr_valid, wr_stb, rd_stb, err;
  logic [15:0] addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_demux i_bus_demux (.*);

  function automatic logic [15:0] exp_addr(logic [7:0] hi, logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [3:0] exp_strobes(logic r, logic w);
    // {addr_valid, wr_stb, rd_stb, ad_oe}
    return {(!r || !w), (!w && r), (!r && w), (!r && w)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_step();
    @(posedge clk); #1;
  endtask

  task automatic access(logic is_rd, logic [15:0] a, logic [7:0] d, logic [7:0] noise);
    drive_step();
    ale = 1; ad_in = a[7:0]; addr_hi = a[15:8];
    @(negedge clk);
    chk("R1 transparent", addr_lo, a[7:0]);
    drive_step();
    ale = 0; ad_in = is_rd ? noise : d;
    @(negedge clk);
    chk("R2 held", addr_lo, a[7:0]);
    chk("R3 idle valid", addr_valid, 0);
    drive_step();
    if (is_rd) begin rd_n = 0; rd_data = d; end else wr_n = 0;
    @(negedge clk);
    chk("R3 addr", addr, exp_addr(a[15:8], a[7:0]));
    chk("R3/R4/R5 strobes", {addr_valid, wr_stb, rd_stb, ad_oe}, exp_strobes(rd_n, wr_n));
    if (is_rd) chk("R5 read data", ad_out, d);
    else       chk("R4 write data", wr_data, d);
    drive_step();
    rd_n = 1; wr_n = 1; ad_in = noise;
    @(negedge clk);
    chk("R2 held after data", addr_lo, a[7:0]);
    chk("R4/R5 released", {addr_valid, wr_stb, rd_stb, ad_oe}, 4'b0000);
    chk("R6 no err", err, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    ad_in = 8'h5C;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R7 reset lo", addr_lo, 8'h00);
    chk("R7 reset err", err, 0);
    chk("R3 reset valid", addr_valid, 0);

    access(0, 16'hFF55, 8'hAA, 8'h3C);
    access(1, 16'h8000, 8'h5A, 8'hC3);
    access(0, 16'h0000, 8'hFF, 8'h00);
    access(1, 16'hFFFF, 8'h00, 8'hFF);

    for (int i = 0; i < 40; i++)
      access($urandom_range(1, 0), 16'($urandom), 8'($urandom), 8'($urandom));

    drive_step();
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    chk("R6 overlap strobes", {wr_stb, rd_stb, ad_oe}, 3'b000);
    chk("R3 overlap valid", addr_valid, 1);
    chk("R6 err not yet", err, 0);
    drive_step();
    rd_n = 1; wr_n = 1;
    @(negedge clk);
    chk("R6 err set", err, 1);
    repeat (3) drive_step();
    @(negedge clk);
    chk("R6 err sticky", err, 1);
    drive_step();
    rst = 1; ale = 1; ad_in = 8'h77;
    drive_step();
    rst = 0; ale = 0;
    @(negedge clk);
    chk("R7 reset clears err", err, 0);
    chk("R7 reset clears lo", addr_lo, 8'h00);
    access(0, 16'h1234, 8'h99, 8'h66);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule